// File: doc/BRIEF.md
# Rate-Matching Progress Counter

This block measures whether a running program keeps up with a target pace. A bounded progress counter moves up by one on every progress pulse that the core retires. It moves down by one each time a programmable divider has counted a set number of ticks of a free-running reference clock. The reference ticks do not depend on the core's supply level, so the decrement pace is an absolute time base. When progress and the time base agree, the counter stays near its midpoint. When they drift apart, the counter reaches one of its limits and a directional exception goes to a voltage-adjust handler.

Software sets a ceiling and a divisor through a small register port. It reads back the counter and two statistics: instructions retired and progress pulses seen since the last acknowledge. It acknowledges an exception by writing the control register. That write re-centres the counter and clears the statistics. A divisor of zero turns the mechanism off, so code that never issues progress pulses runs unaffected.

The reference clock enters as a one-cycle tick pulse synchronous to `clk_i`.

Top module: `rate_match_unit`

## Requirements
- R1: While enabled and with no exception pending, a progress pulse without a same-cycle decrement raises the counter (address 3) by one.
- R2: With divisor D (address 2, 24 bits, D>0), one decrement occurs on every D-th reference tick after the divisor was written.
- R3: A counter value reaching 0 sets `exc_o` with `exc_dir_o`=0. A counter value reaching the ceiling (address 1) sets `exc_o` with `exc_dir_o`=1. The control register (address 0) reads flag in bit 0 and direction in bit 1.
- R4: Reset leaves the ceiling at `CEIL_RST`, the counter at `CEIL_RST/2`, the divisor at 0 and no exception.
- R5: With the divisor at 0, progress pulses and reference ticks leave the counter unchanged and no exception is raised.
- R6: While an exception is pending, the counter, flag and direction hold until acknowledged.
- R7: A progress pulse and a decrement in the same cycle cancel, and the counter holds.
- R8: Any write to address 0 clears the exception, reloads the counter to half the ceiling, and clears the retired-instruction count (address 4) and the progress count (address 5).
- R9: Writing the ceiling reloads the counter to half the new ceiling and clears any exception. With a ceiling of 2, a single increment or decrement from that point raises an exception.
- R10: Writing the divisor restarts the divider. Ticks that arrived before the write do not count toward the next decrement.
- R11: Addresses 4 and 5 count retire and progress pulses since the last acknowledge, including pulses that arrive while the counter is disabled or frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| progress_i | input | 1 | Progress pulse from a retired progress instruction |
| retire_i | input | 1 | Instruction-retired pulse |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| exc_o | output | 1 | Counter exception pending |
| exc_dir_o | output | 1 | Exception direction: 0 too slow, 1 too fast |

## Verification
The bench places a progress pulse on the same edge as the decrement, so a design that let either side win would drift by one. It writes the divisor in the middle of a count, so a divider that kept its old state would fire one period early. It pulses progress while an exception is pending, so a counter that kept moving would pass the ceiling and make the handler's readback useless. It also sets the ceiling to 2 to check that a single step from the midpoint trips in each direction. It pulses progress with the divisor at zero to check that the counter and flag do not move.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_CEIL    = 3'd1,
    RA_DIV     = 3'd2,
    RA_CNT     = 3'd3,
    RA_RETIRED = 3'd4,
    RA_PROG    = 3'd5
  } rmu_addr_e;

  localparam logic DIR_SLOW = 1'b0;
  localparam logic DIR_FAST = 1'b1;
endpackage

// File: rtl/rmu_divider.sv
module rmu_divider #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             dec_o
);
  logic [DIV_W-1:0] left_q;
  logic             en;

  assign en    = (div_i != '0);
  assign dec_o = tick_i && en && (left_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= load_val_i - DIV_W'(1);
    end else if (tick_i && en) begin
      left_q <= (left_q == '0) ? div_i - DIV_W'(1) : left_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/rmu_counter.sv
module rmu_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic [CNT_W-1:0] rst_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             dir_o
);
  import rmu_pkg::*;

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             flag_q, dir_q;

  always_comb begin
    nxt = cnt_q;
    if (inc_i && !dec_i)      nxt = cnt_q + CNT_W'(1);
    else if (dec_i && !inc_i) nxt = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= rst_val_i;
      flag_q <= 1'b0;
      dir_q  <= DIR_SLOW;
    end else if (reload_i) begin
      cnt_q  <= reload_val_i;
      flag_q <= 1'b0;
      dir_q  <= DIR_SLOW;
    end else if (!flag_q && en_i) begin
      cnt_q <= nxt;
      if (nxt == '0) begin
        flag_q <= 1'b1;
        dir_q  <= DIR_SLOW;
      end else if (nxt >= ceil_i) begin
        flag_q <= 1'b1;
        dir_q  <= DIR_FAST;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/rmu_stat_ctr.sv
module rmu_stat_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         pulse_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clr_i)   q <= '0;
    else if (pulse_i) q <= q + W'(1);
  end

  assign q_o = q;
endmodule

// File: rtl/rate_match_unit.sv
module rate_match_unit #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_W    = 24,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned CEIL_RST = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        progress_i,
  input  logic        retire_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        exc_o,
  output logic        exc_dir_o
);
  import rmu_pkg::*;

  localparam int unsigned N_STAT = 2;

  logic [CNT_W-1:0]  ceil_q, cnt_w, reload_val;
  logic [DIV_W-1:0]  div_q;
  logic              wr_ctrl, wr_ceil, wr_div, en_w, dec_w;
  logic [N_STAT-1:0] stat_pulse;
  logic [STAT_W-1:0] stat_q [N_STAT];

  assign wr_ctrl = we_i && (addr_i == RA_CTRL);
  assign wr_ceil = we_i && (addr_i == RA_CEIL);
  assign wr_div  = we_i && (addr_i == RA_DIV);
  assign en_w    = (div_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ceil_q <= CNT_W'(CEIL_RST);
      div_q  <= '0;
    end else begin
      if (wr_ceil) ceil_q <= wdata_i[CNT_W-1:0];
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
    end
  end

  assign reload_val = wr_ceil ? (wdata_i[CNT_W-1:0] >> 1) : (ceil_q >> 1);

  rmu_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ref_tick_i),
    .load_i     (wr_div),
    .load_val_i (wdata_i[DIV_W-1:0]),
    .div_i      (div_q),
    .dec_o      (dec_w)
  );

  rmu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_w),
    .inc_i        (progress_i),
    .dec_i        (dec_w),
    .reload_i     (wr_ctrl || wr_ceil),
    .reload_val_i (reload_val),
    .ceil_i       (ceil_q),
    .rst_val_i    (CNT_W'(CEIL_RST / 2)),
    .cnt_o        (cnt_w),
    .flag_o       (exc_o),
    .dir_o        (exc_dir_o)
  );

  assign stat_pulse = {progress_i, retire_i};

  for (genvar g = 0; g < N_STAT; g++) begin : g_stat
    rmu_stat_ctr #(.W(STAT_W)) u_stat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (wr_ctrl),
      .pulse_i (stat_pulse[g]),
      .q_o     (stat_q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:    rdata_o = {30'd0, exc_dir_o, exc_o};
      RA_CEIL:    rdata_o = DATA_W'(ceil_q);
      RA_DIV:     rdata_o = DATA_W'(div_q);
      RA_CNT:     rdata_o = DATA_W'(cnt_w);
      RA_RETIRED: rdata_o = DATA_W'(stat_q[0]);
      RA_PROG:    rdata_o = DATA_W'(stat_q[1]);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rmu_chk.sv
module rmu_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ceil,
  input logic             flag,
  input logic             dir,
  input logic             prog,
  input logic             dec,
  input logic             en,
  input logic             wr_ctrl,
  input logic             wr_ceil
);
  assert_inc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && en && prog && !dec && !wr_ctrl && !wr_ceil) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_exc_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> (dir ? (cnt >= ceil) : (cnt == '0)));

  assert_ack_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (!flag && cnt == ($past(ceil) >> 1)));

  assert_off_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_ctrl && !wr_ceil) |=> ($stable(cnt) && !$rose(flag)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !wr_ctrl && !wr_ceil) |=> (flag && $stable(dir) && $stable(cnt)));

  assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog && dec && !wr_ctrl && !wr_ceil) |=> $stable(cnt));
endmodule

bind rate_match_unit rmu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt     (cnt_w),
  .ceil    (ceil_q),
  .flag    (exc_o),
  .dir     (exc_dir_o),
  .prog    (progress_i),
  .dec     (dec_w),
  .en      (en_w),
  .wr_ctrl (wr_ctrl),
  .wr_ceil (wr_ceil)
);

// File: tb/rate_match_unit_tb.sv
module rate_match_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, prog = 1'b0, retire = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        exc, exc_dir;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_match_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick), .progress_i(prog),
    .retire_i(retire), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .exc_o(exc), .exc_dir_o(exc_dir)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    addr = a; #1;
    check(req, int'(rdata), exp);
  endtask

  task automatic pulse(input bit p, input bit t, input bit r);
    @(negedge clk); prog = p; tick = t; retire = r;
    @(negedge clk); prog = 0; tick = 0; retire = 0;
  endtask

  task automatic t_reset;
    rd_chk("R4 ceil", 3'd1, 8);
    rd_chk("R4 cnt", 3'd3, 4);
    rd_chk("R4 div", 3'd2, 0);
    rd_chk("R4 ctrl", 3'd0, 0);
  endtask

  task automatic t_disabled;
    for (int i = 0; i < 5; i++) pulse(1, 1, 0);
    rd_chk("R5 cnt", 3'd3, 4);
    rd_chk("R5 ctrl", 3'd0, 0);
    rd_chk("R11 prog stat", 3'd5, 5);
  endtask

  task automatic t_inc_dec;
    wr(3'd2, 3);
    wr(3'd0, 0);
    rd_chk("R8 stat clr", 3'd5, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    rd_chk("R1 cnt", 3'd3, 6);
    pulse(0, 1, 0); pulse(0, 1, 0);
    rd_chk("R2 early", 3'd3, 6);
    pulse(0, 1, 0);
    rd_chk("R2 dec", 3'd3, 5);
  endtask

  task automatic t_cancel;
    pulse(0, 1, 0); pulse(0, 1, 0);
    pulse(1, 1, 0);
    rd_chk("R7 cnt", 3'd3, 5);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++) pulse(0, 0, 1);
    pulse(1, 0, 0); pulse(1, 0, 0);
    rd_chk("R3 no exc yet", 3'd0, 0);
    pulse(1, 0, 0);
    rd_chk("R3 fast", 3'd0, 3);
    pulse(1, 0, 0);
    rd_chk("R6 cnt frozen", 3'd3, 8);
    rd_chk("R6 flag held", 3'd0, 3);
    rd_chk("R11 prog stat", 3'd5, 7);
    rd_chk("R11 retire stat", 3'd4, 4);
    wr(3'd0, 0);
    rd_chk("R8 cnt", 3'd3, 4);
    rd_chk("R8 ctrl", 3'd0, 0);
    rd_chk("R8 retire clr", 3'd4, 0);
    rd_chk("R8 prog clr", 3'd5, 0);
  endtask

  task automatic t_underflow;
    wr(3'd2, 1);
    for (int i = 0; i < 3; i++) pulse(0, 1, 0);
    rd_chk("R3 cnt 1", 3'd3, 1);
    pulse(0, 1, 0);
    rd_chk("R3 slow", 3'd0, 1);
    rd_chk("R3 cnt 0", 3'd3, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_ceil2;
    wr(3'd1, 2);
    rd_chk("R9 reload", 3'd3, 1);
    pulse(1, 0, 0);
    rd_chk("R9 fast", 3'd0, 3);
    wr(3'd0, 0);
    pulse(0, 1, 0);
    rd_chk("R9 slow", 3'd0, 1);
    wr(3'd1, 8);
    rd_chk("R9 back", 3'd0, 0);
  endtask

  task automatic t_div_restart;
    wr(3'd2, 4);
    pulse(0, 1, 0); pulse(0, 1, 0);
    wr(3'd2, 3);
    pulse(0, 1, 0); pulse(0, 1, 0);
    rd_chk("R10 no dec", 3'd3, 4);
    pulse(0, 1, 0);
    rd_chk("R10 dec", 3'd3, 3);
    rd_chk("R2 div rb", 3'd2, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_inc_dec();
    t_cancel();
    t_overflow();
    t_underflow();
    t_ceil2();
    t_div_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule